// File: doc/BRIEF.md
# Auto-Read Fuse Word Controller

This block reads one 32-bit word from a 128-byte one-time-programmable fuse array. Software issues a single register write that names a word address. The block then drives the array's select, load and strobe lines itself, so software does no pin timing. When the read is over, the block stores the word in a data register and raises a completion flag. Software clears that flag by writing a one to it.

Words 0 to 23 form the secure region, which is bytes 0 to 95. Words 24 to 31 are non-secure, which is bytes 96 to 127. An input pin can confine reads to the non-secure region. A behavioural model of the fuse array is part of the project. Its contents come from a fixed formula, so a bench can predict every word.

The read time is a fixed number of cycles, derived from a clock-frequency parameter. It stays well inside a 4 µs limit. Register reads are combinational on the address bus.

Top module: `fuse_autoread`

## Requirements
- R1: After reset, the status register at offset 0x18, the data register at 0x20 and the control register at 0x24 all read 0.
- R2: A read starts only when a write to offset 0x24 has both bit 0 (enable) and bit 1 (read command) set. The word address is taken from bits 25:16 of that write. A write with only one of the two bits set starts nothing.
- R3: Bit 0 of offset 0x18 becomes 1 exactly SETUP+STROBE cycles after the clock edge that accepts the command. SETUP is 4. STROBE is CLK_MHZ/2, with a minimum of 1. At 100 MHz this is 54 cycles, which is no more than 64 cycles and under 4 µs.
- R4: In the fuse array model, byte b holds (53*b + 167) mod 256. Offset 0x20 returns word w with byte 4w in bits 7:0, byte 4w+1 in bits 15:8, and so on up to bits 31:24. The data register keeps its value until the next read completes.
- R5: A command written while a read is in progress is ignored. The address, the data and the timing of the current read are unaffected.
- R6: Writing 1 to bit 0 of offset 0x18 clears the flag. Writing 0 there has no effect. If the clear lands in the same cycle as a completion, the flag stays set.
- R7: A word address of 32 or more returns all zeros, and the flag is still set after the normal latency.
- R8: The nonsec_only input is sampled when a command is accepted. If it was high, a read of words 0 to 23 returns zero. Reads of words 24 to 31 return normal data regardless of nonsec_only.
- R9: Offset 0x24 reads bit 0 as 1 while a read is in progress. Bits 25:16 hold the last accepted word address. All other bits read 0, and any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe for one cycle |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| nonsec_only | input | 1 | Restricts reads to the non-secure words |

## Verification
Suppose the sequencer's cycle counter or state is corrupted. Then the busy bit at offset 0x24 and the flag at offset 0x18 change on the wrong cycle. The cycle-accurate model in the bench flags this on the very next clock. A wrong latched address or security decision does not show until the read completes: the data register then holds the wrong word, at most 54 cycles after the command. A faulty clear or collision rule appears in the status bit one cycle after the write.

// File: rtl/fuse_array_model.sv
module fuse_array_model #(
  parameter int AW    = 10,
  parameter int WORDS = 32
) (
  input  logic          csb,
  input  logic          load,
  input  logic          strobe,
  input  logic [AW-1:0] addr,
  output logic [31:0]   dout
);
  function automatic logic [7:0] byte_at(input int b);
    return 8'((b * 53 + 167) % 256);
  endfunction

  always_comb begin
    dout = '0;
    if (!csb && load && strobe && int'(addr) < WORDS)
      for (int k = 0; k < 4; k++)
        dout[8*k +: 8] = byte_at(int'(addr) * 4 + k);
  end
endmodule

// File: rtl/fuse_autoread.sv
module fuse_autoread #(
  parameter int CLK_MHZ      = 100,
  parameter int AW           = 10,
  parameter int WORDS        = 32,
  parameter int SECURE_WORDS = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        nonsec_only
);
  localparam int SETUP_CYC = 4;
  localparam int STRB_CYC  = (CLK_MHZ / 2 > 0) ? CLK_MHZ / 2 : 1;
  localparam int CW        = $clog2(SETUP_CYC + STRB_CYC + 1);
  localparam logic [7:0] OFS_STAT = 8'h18;
  localparam logic [7:0] OFS_DATA = 8'h20;
  localparam logic [7:0] OFS_CTRL = 8'h24;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STRB} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] waddr_q;
  logic          blk_q;
  logic [31:0]   dout_q;
  logic          fin_q;
  logic          arr_csb, arr_load, arr_strb;
  logic [31:0]   arr_dout;
  logic          unused_bits;

  wire busy = (st != S_IDLE);
  wire cmd  = reg_wr && reg_addr == OFS_CTRL && reg_wdata[0] && reg_wdata[1];
  wire go   = cmd && !busy;
  wire cap  = (st == S_STRB) && (cnt == '0);
  wire clr  = reg_wr && reg_addr == OFS_STAT && reg_wdata[0];
  wire secure_hit = blk_q && (int'(waddr_q) < SECURE_WORDS);

  assign arr_csb  = !busy;
  assign arr_load = busy;
  assign arr_strb = (st == S_STRB);
  assign unused_bits = ^{reg_wdata[15:2], reg_wdata >> (16 + AW)};

  fuse_array_model #(.AW(AW), .WORDS(WORDS)) u_array (
    .csb(arr_csb), .load(arr_load), .strobe(arr_strb),
    .addr(waddr_q), .dout(arr_dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      waddr_q <= '0;
      blk_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (go) begin
            st      <= S_SETUP;
            cnt     <= CW'(SETUP_CYC - 1);
            waddr_q <= reg_wdata[16 +: AW];
            blk_q   <= nonsec_only;
          end
        S_SETUP:
          if (cnt == '0) begin
            st  <= S_STRB;
            cnt <= CW'(STRB_CYC - 1);
          end else cnt <= cnt - 1'b1;
        S_STRB:
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      fin_q  <= 1'b0;
    end else begin
      if (cap) dout_q <= secure_hit ? '0 : arr_dout;
      if (cap) fin_q <= 1'b1;
      else if (clr) fin_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_STAT: reg_rdata[0] = fin_q;
      OFS_DATA: reg_rdata = dout_q;
      OFS_CTRL: begin
        reg_rdata[16 +: AW] = waddr_q;
        reg_rdata[0]        = busy;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

module fuse_autoread_chk #(
  parameter int AW  = 10,
  parameter int LAT = 54,
  parameter int SEC = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [7:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          busy,
  input logic          arr_csb,
  input logic          arr_strb,
  input logic          fin_q,
  input logic          cap,
  input logic          blk_q,
  input logic [AW-1:0] waddr_q,
  input logic [31:0]   dout_q
);
  int run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= 0;
    else run <= busy ? run + 1 : 0;

  // R3
  strobe_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_strb |-> !arr_csb);
  // R3
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run < LAT);
  // R3
  flag_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin_q) |-> $past(busy));
  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_wr && reg_addr == 8'h24 && reg_wdata[1:0] == 2'b11) |=> busy);
  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(waddr_q));
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h18 && reg_wdata[0] && !cap) |=> !fin_q);
  // R8
  secure_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && blk_q && int'(waddr_q) < SEC) |=> dout_q == '0);
endmodule

bind fuse_autoread fuse_autoread_chk #(
  .AW(AW), .LAT(SETUP_CYC + STRB_CYC), .SEC(SECURE_WORDS)
) chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .arr_csb(arr_csb), .arr_strb(arr_strb),
  .fin_q(fin_q), .cap(cap), .blk_q(blk_q), .waddr_q(waddr_q), .dout_q(dout_q)
);

// File: tb/fuse_autoread_test.sv
module fuse_autoread_test;
  localparam int LAT = 54;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        nonsec_only = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  int          m_cnt = 0;
  bit          m_fin = 0;
  logic [31:0] m_data = 0;
  logic [9:0]  m_addr = 0;
  bit          m_blk = 0;

  fuse_autoread uut (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] exp_word(input int w, input bit blk);
    logic [31:0] r = '0;
    if (w >= 32 || (blk && w < 24)) return '0;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = 8'(((4*w + k) * 53 + 167) % 256);
    return r;
  endfunction

  function automatic logic [31:0] cmdw(input int w, input logic [1:0] bits);
    return (32'(w) << 16) | 32'(bits);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    reg_wr = 0;
    reg_addr = 8'h18; #1 chk({tag, " R3 status"}, reg_rdata, {31'b0, m_fin});
    reg_addr = 8'h20; #1 chk({tag, " R4 data"}, reg_rdata, m_data);
    reg_addr = 8'h24; #1 chk({tag, " R9 ctrl"}, reg_rdata,
                             (32'(m_addr) << 16) | 32'(m_cnt > 0));
    reg_addr = 8'h04; #1 chk({tag, " R9 other"}, reg_rdata, 32'h0);
  endtask

  task automatic cyc(input bit wr, input logic [7:0] a, input logic [31:0] d, input string tag);
    bit set_now = 0;
    @(negedge clk);
    compare_all(tag);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (rst_n) begin
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_fin = 1; set_now = 1;
          m_data = exp_word(int'(m_addr), m_blk);
        end
      end else if (wr && a == 8'h24 && d[1:0] == 2'b11) begin
        m_cnt = LAT; m_addr = d[25:16]; m_blk = nonsec_only;
      end
      if (wr && a == 8'h18 && d[0] && !set_now) m_fin = 0;
    end
    #1 reg_wr = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 32'h0, tag);
  endtask

  task automatic read_word(input int w, input string tag);
    cyc(1, 8'h24, cmdw(w, 2'b11), tag);
    idle(LAT + 1, tag);
    cyc(1, 8'h18, 32'h1, tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    idle(2, "R1 reset");
    @(negedge clk); rst_n = 1;
    idle(2, "R1 after reset");

    // R2, R4: plain reads, boundary words
    cyc(1, 8'h24, cmdw(25, 2'b11), "R2 start");
    idle(LAT + 2, "R4 word25");
    chk("R4 word25 direct", m_data, exp_word(25, 0));
    cyc(1, 8'h18, 32'h0, "R6 write zero");
    idle(1, "R6 write zero held");
    cyc(1, 8'h18, 32'h1, "R6 clear");
    idle(1, "R6 cleared");
    read_word(0, "R4 word0");
    read_word(31, "R4 word31");

    // R2: single-bit commands do nothing
    cyc(1, 8'h24, cmdw(7, 2'b01), "R2 enable only");
    idle(3, "R2 enable only");
    cyc(1, 8'h24, cmdw(7, 2'b10), "R2 read only");
    idle(3, "R2 read only");

    // R3: latency measured at the ports
    cyc(1, 8'h24, cmdw(26, 2'b11), "R3 latency");
    n = 0;
    while (n < 100) begin
      cyc(0, 8'h00, 32'h0, "R3 latency");
      n++;
      reg_addr = 8'h18; #1;
      if (reg_rdata[0]) break;
    end
    chk("R3 latency cycles", 32'(n), 32'(LAT));
    chk("R3 within 64", 32'(n <= 64), 32'h1);
    cyc(1, 8'h18, 32'h1, "R3 clear");

    // R5: command while busy ignored
    cyc(1, 8'h24, cmdw(30, 2'b11), "R5 first");
    idle(10, "R5 busy");
    cyc(1, 8'h24, cmdw(2, 2'b11), "R5 second ignored");
    idle(LAT, "R5 busy");
    chk("R5 kept word30", m_data, exp_word(30, 0));
    cyc(1, 8'h18, 32'h1, "R5 clear");

    // R7: out of range
    read_word(40, "R7 word40");
    chk("R7 word40 zero", m_data, 32'h0);
    read_word(1023, "R7 word1023");

    // R8: non-secure restriction
    nonsec_only = 1;
    read_word(5, "R8 secure blocked");
    chk("R8 blocked zero", m_data, 32'h0);
    read_word(23, "R8 word23 blocked");
    read_word(24, "R8 word24 allowed");
    chk("R8 word24", m_data, exp_word(24, 0));
    cyc(1, 8'h24, cmdw(3, 2'b11), "R8 latched");
    nonsec_only = 0;
    idle(LAT + 1, "R8 latched");
    cyc(1, 8'h18, 32'h1, "R8 latched clear");
    read_word(5, "R8 secure open");

    // R6: clear colliding with completion
    cyc(1, 8'h24, cmdw(28, 2'b11), "R6 collide");
    idle(LAT - 1, "R6 collide");
    cyc(1, 8'h18, 32'h1, "R6 collide clear");
    idle(2, "R6 flag stays");
    chk("R6 flag after collision", 32'(m_fin), 32'h1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule